// File: doc/BRIEF.md
# Edge Event Counter on Port Pin 7

This block keeps the input latch of an 8-bit general port and counts transitions on its top pin. An external agent posts new pin levels through a write strobe. Only some bits take the new value: bits 1 and 0 always do, and bit 7 does too when its direction bit marks it as an input. Every other bit keeps the value it held before.

A change of bit 7 can advance an 8-bit counter by one. The counter advances only when three things hold: the control register enables it, the control register selects event mode rather than gated-time mode, and the new level of bit 7 matches the chosen edge. When an increment takes the counter from all ones to zero, a sticky overflow flag is set. An interrupt request is raised while that flag and its enable bit are both 1. Gated-time accumulation is not implemented, so selecting that mode stops all counting. The processor can load the counter directly, and it clears the flag by writing a 1 to it.

Top module: `pulse_evt_counter`

## Requirements
- R1: After reset, port_q, count, cfg_q, ovf_flag and irq are all 0.
- R2: An ext_wr updates port_q bits 1:0 from ext_data. Bit 7 is updated too, but only when pin7_is_out is 0. Bits 6:2, and bit 7 while pin7_is_out is 1, keep their previous value.
- R3: The counter can only advance on a cycle where ext_wr changes port_q[7]. An ext_wr that leaves bit 7 unchanged does not move the counter.
- R4: Counting requires cfg_q[0] (enable) = 1 and cfg_q[1] (gated-time mode) = 0. In any other setting, a change of bit 7 leaves count unchanged.
- R5: With cfg_q[2] = 1 the counter advances when bit 7 becomes 1. With cfg_q[2] = 0 it advances when bit 7 becomes 0.
- R6: An increment from 8'hFF to 8'h00 sets ovf_flag on the same clock edge. The flag then stays at 1.
- R7: A flag_wr with flag_wdata = 1 clears ovf_flag. If an overflow occurs in the same cycle, the set wins. A flag_wr with flag_wdata = 0 has no effect.
- R8: irq is 1 exactly when ovf_flag = 1 and cfg_q[3] (interrupt enable) = 1.
- R9: cnt_we loads cnt_wdata into count on the next edge. This load takes priority over an increment in the same cycle, and that lost increment does not set ovf_flag.
- R10: cfg_we loads cfg_wdata[3:0] into cfg_q on the next edge. An ext_wr in the same cycle is judged with the previous cfg_q.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_wr | input | 1 | External pin-level update strobe |
| ext_data | input | 8 | New pin levels |
| pin7_is_out | input | 1 | 1 = pin 7 is an output, so its external level is ignored |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 4 | Control value: bit0 enable, bit1 gated mode, bit2 rising edge, bit3 interrupt enable |
| cnt_we | input | 1 | Counter load strobe |
| cnt_wdata | input | 8 | Counter load value |
| flag_wr | input | 1 | Flag register write strobe |
| flag_wdata | input | 1 | Value written to the flag; 1 clears it |
| port_q | output | 8 | Latched port levels |
| cfg_q | output | 4 | Control register |
| count | output | 8 | Event count |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Interrupt request |

## Verification
Directed sequences step bit 7 through both edge polarities, through repeated writes at the same level, and through each enable and mode setting. Together these separate edge detection from level detection, and real counting from suppressed counting. Further directed cases preload the counter near all ones, so that a wrap is tested alone, together with a flag clear, and together with a counter load. This shows how set, clear and load are ordered against each other. A long random mix of all strobes, including changes of the direction bit, is compared each cycle with a bench reference model. This exposes any mask bit or update-order error that the directed cases miss.

// File: rtl/pulse_evt_counter.sv
module pulse_evt_counter #(
  parameter int CNT_W  = 8,
  parameter int PORT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_wr,
  input  logic [PORT_W-1:0] ext_data,
  input  logic              pin7_is_out,
  input  logic              cfg_we,
  input  logic [3:0]        cfg_wdata,
  input  logic              cnt_we,
  input  logic [CNT_W-1:0]  cnt_wdata,
  input  logic              flag_wr,
  input  logic              flag_wdata,
  output logic [PORT_W-1:0] port_q,
  output logic [3:0]        cfg_q,
  output logic [CNT_W-1:0]  count,
  output logic              ovf_flag,
  output logic              irq
);
  localparam int TOP = PORT_W - 1;
  localparam logic [PORT_W-1:0] LOW_MASK = PORT_W'(3);
  localparam logic [PORT_W-1:0] TOP_BIT  = PORT_W'(1) << TOP;
  localparam logic [CNT_W-1:0]  CNT_MAX  = '1;

  logic [PORT_W-1:0] in_mask, port_nx;
  logic              edge_hit, counting, tick, wrap;

  assign in_mask  = pin7_is_out ? LOW_MASK : (LOW_MASK | TOP_BIT);
  assign port_nx  = (ext_data & in_mask) | (port_q & ~in_mask);
  assign edge_hit = ext_wr && (port_nx[TOP] != port_q[TOP]) &&
                    (cfg_q[2] ? port_nx[TOP] : !port_nx[TOP]);
  assign counting = cfg_q[0] && !cfg_q[1];
  assign tick     = edge_hit && counting;
  assign wrap     = tick && !cnt_we && (count == CNT_MAX);
  assign irq      = ovf_flag && cfg_q[3];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      port_q   <= '0;
      cfg_q    <= '0;
      count    <= '0;
      ovf_flag <= 1'b0;
    end else begin
      if (ext_wr) port_q <= port_nx;
      if (cfg_we) cfg_q <= cfg_wdata;
      if (cnt_we) count <= cnt_wdata;
      else if (tick) count <= count + 1'b1;
      if (wrap) ovf_flag <= 1'b1;
      else if (flag_wr && flag_wdata) ovf_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/pulse_evt_counter_chk.sv
module pulse_evt_counter_chk #(
  parameter int CNT_W  = 8,
  parameter int PORT_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ext_wr,
  input logic              pin7_is_out,
  input logic              cnt_we,
  input logic [CNT_W-1:0]  cnt_wdata,
  input logic              flag_wr,
  input logic              flag_wdata,
  input logic [PORT_W-1:0] port_q,
  input logic [3:0]        cfg_q,
  input logic [CNT_W-1:0]  count,
  input logic              ovf_flag,
  input logic              irq
);
  assert_mid_bits_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(port_q[PORT_W-2:2]));
  assert_pin7_out_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pin7_is_out |=> $stable(port_q[PORT_W-1]));
  assert_no_write_no_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_wr && !cnt_we) |=> $stable(count));
  assert_disabled_no_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((!cfg_q[0] || cfg_q[1]) && !cnt_we) |=> $stable(count));
  assert_wrap_sets_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0 && $past(count) == '1 && !$past(cnt_we) && $past(rst_n)) |-> ovf_flag);
  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !(flag_wr && flag_wdata)) |=> ovf_flag);
  assert_irq_needs_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ovf_flag);
  assert_load_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |=> (count == $past(cnt_wdata)));
endmodule

bind pulse_evt_counter pulse_evt_counter_chk #(.CNT_W(CNT_W), .PORT_W(PORT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ext_wr(ext_wr), .pin7_is_out(pin7_is_out),
  .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .flag_wr(flag_wr), .flag_wdata(flag_wdata),
  .port_q(port_q), .cfg_q(cfg_q), .count(count), .ovf_flag(ovf_flag), .irq(irq));

// File: tb/tb_pulse_evt_counter.sv
module tb_pulse_evt_counter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ext_wr = 1'b0, pin7_is_out = 1'b0, cfg_we = 1'b0, cnt_we = 1'b0;
  logic       flag_wr = 1'b0, flag_wdata = 1'b0;
  logic [7:0] ext_data = '0, cnt_wdata = '0;
  logic [3:0] cfg_wdata = '0;
  logic [7:0] port_q, count;
  logic [3:0] cfg_q;
  logic       ovf_flag, irq;

  int tests = 0, fails = 0;
  logic [7:0] m_port = '0, m_cnt = '0;
  logic [3:0] m_cfg = '0;
  logic       m_flag = 1'b0;

  always #2 clk = ~clk;

  pulse_evt_counter dut (
    .clk(clk), .rst_n(rst_n), .ext_wr(ext_wr), .ext_data(ext_data),
    .pin7_is_out(pin7_is_out), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .flag_wr(flag_wr),
    .flag_wdata(flag_wdata), .port_q(port_q), .cfg_q(cfg_q), .count(count),
    .ovf_flag(ovf_flag), .irq(irq));

  function automatic logic [7:0] f_port(logic [7:0] p, logic [7:0] d, logic dir);
    logic [7:0] m = dir ? 8'h03 : 8'h83;
    return (d & m) | (p & ~m);
  endfunction

  function automatic logic f_tick(logic [7:0] p, logic [7:0] np, logic [3:0] c);
    return (np[7] != p[7]) && c[0] && !c[1] && (c[2] ? np[7] : !np[7]);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    chk({tag, " port"}, port_q, m_port);
    chk({tag, " count"}, count, m_cnt);
    chk({tag, " cfg"}, cfg_q, m_cfg);
    chk({tag, " flag"}, ovf_flag, m_flag);
    chk({tag, " irq R8"}, irq, m_flag & m_cfg[3]);
  endtask

  task automatic step(string tag, logic ew, logic [7:0] ed, logic dir,
                      logic cw, logic [3:0] cd, logic nw, logic [7:0] nd,
                      logic fw, logic fd);
    logic [7:0] np;
    logic tk, setf;
    @(negedge clk);
    ext_wr = ew; ext_data = ed; pin7_is_out = dir; cfg_we = cw; cfg_wdata = cd;
    cnt_we = nw; cnt_wdata = nd; flag_wr = fw; flag_wdata = fd;
    np = ew ? f_port(m_port, ed, dir) : m_port;
    tk = ew && f_tick(m_port, np, m_cfg);
    setf = tk && !nw && (m_cnt == 8'hFF);
    m_port = np;
    m_cnt = nw ? nd : m_cnt + {7'd0, tk};
    m_flag = setf | (m_flag & !(fw && fd));
    if (cw) m_cfg = cd;
    @(posedge clk);
    #1;
    ext_wr = 0; cfg_we = 0; cnt_we = 0; flag_wr = 0;
    check_all(tag);
  endtask

  task automatic pin(string tag, logic [7:0] d, logic dir);
    step(tag, 1, d, dir, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic cfg(logic [3:0] c);
    step("R10 cfg", 0, 0, 0, 1, c, 0, 0, 0, 0);
  endtask
  task automatic load(logic [7:0] v);
    step("R9 load", 0, 0, 0, 0, 0, 1, v, 0, 0);
  endtask

  initial begin
    #150000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0123));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    check_all("R1 reset");

    pin("R2 mid bits ignored", 8'h7C, 0);
    pin("R2 low bits", 8'h03, 0);
    pin("R2 pin7 as output ignored", 8'h80, 1);
    pin("R4 disabled no count", 8'h80, 0);
    pin("R4 disabled fall", 8'h00, 0);
    cfg(4'b0011);
    pin("R4 gated no count", 8'h80, 0);
    pin("R4 gated fall", 8'h00, 0);
    cfg(4'b0001);
    pin("R5 rise ignored falling mode", 8'h80, 0);
    pin("R5 fall counts", 8'h00, 0);
    pin("R3 same level no count", 8'h01, 0);
    pin("R3 same level again", 8'h02, 0);
    cfg(4'b0101);
    pin("R5 rising counts", 8'h80, 0);
    pin("R5 fall ignored rising mode", 8'h00, 0);
    cfg(4'b1101);
    load(8'hFE);
    pin("R6 to FF", 8'h80, 0);
    pin("R6 low", 8'h00, 0);
    pin("R6 wrap sets flag", 8'h80, 0);
    pin("R6 sticky", 8'h00, 0);
    step("R7 write 0 no effect", 0, 0, 0, 0, 0, 0, 0, 1, 0);
    step("R7 clear", 0, 0, 0, 0, 0, 0, 0, 1, 1);
    load(8'hFF);
    step("R7 set beats clear", 1, 8'h80, 0, 0, 0, 0, 0, 1, 1);
    step("R7 clear again", 0, 0, 0, 0, 0, 0, 0, 1, 1);
    pin("R9 prep low", 8'h00, 0);
    load(8'hFF);
    step("R9 load beats wrap", 1, 8'h80, 0, 0, 0, 1, 8'h42, 0, 0);
    pin("R9 prep low2", 8'h00, 0);
    step("R10 old cfg used", 1, 8'h80, 0, 1, 4'b0000, 0, 0, 0, 0);

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r = $urandom;
      step("R2 R3 R4 R5 R6 R7 R8 R9 R10 random",
           r[0] | r[1], $urandom, r[2] & r[3], r[4] & r[5] & r[6], $urandom,
           r[7] & r[8] & r[9] & r[10], (r[11] ? 8'hFF : $urandom),
           r[12] & r[13], r[14]);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule